// File: doc/BRIEF.md
# TPM SPI Register Transaction Master

This block is an SPI master that runs exactly one register access against a TPM-style device for each request. A requester presents a direction, a payload length and a 24-bit register address. The block then drives chip select low, sends a four-byte command header, and handles the device's wait-state handshake. It moves the payload bytes, releases chip select, and reports completion, with an error flag if the device never became ready.

Payload bytes enter and leave through plain valid/ready byte streams. When a stream is not ready, the SPI clock pauses between bytes; it never pauses inside a byte. The serial interface runs in SPI mode 0, with the clock idling low, data sampled on the rising edge and changed on the falling edge. Its half period is a fixed number of system clocks set by a parameter. The wait-state limit is a second parameter, counted in system clock cycles. Typical targets are the locality-0 window at 0xD40000, with the status register at offset 0x18, the data FIFO at 0x24 and the identity register at 0xF00.

Top module: `tpm_spi_xact`

## Requirements
- R1: The first header byte sent is {read, 1, lenM1}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 carry the payload length minus one.
- R2: Header bytes two to four carry the 24-bit register address, most significant byte first. Every byte on the wire goes out most significant bit first.
- R3: Chip select goes low before the first rising SCLK edge and stays low without a break through the header, any wait polling and the whole payload. A transaction has exactly one low period. SCLK is low whenever chip select is high, and MOSI is stable while SCLK is high.
- R4: If bit 0 of the byte received during the fourth header byte is 1, the first payload byte follows the header directly.
- R5: If that bit is 0, the master sends 0x00 poll bytes one at a time until a received byte has bit 0 set. That byte is not delivered as payload, and the payload follows it.
- R6: If polling lasts more than TIMEOUT_CYC system cycles, the master releases chip select at the end of the current poll byte. It transfers no payload, takes no write data, and signals done together with flowErr.
- R7: A read that fails by timeout still returns exactly lenM1+1 bytes on the read stream, and every one of them is 0x00.
- R8: A write takes exactly lenM1+1 bytes from the write stream, one per handshake, and sends them in order.
- R9: A read sends 0x00 during the payload and delivers exactly lenM1+1 received bytes in order. A low rdReady stalls the transfer without losing a byte.
- R10: A request is accepted only while reqReady is high. Busy stays high from acceptance until chip select has been released. Done is a single-cycle pulse, and request inputs that change during a transaction have no effect on it.
- R11: The maximum length of 64 bytes (lenM1 = 63) is transferred completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqLenM1 | input | 6 | Payload length minus one |
| reqAddr | input | 24 | Register address |
| wrData | input | 8 | Write payload byte |
| wrValid | input | 1 | Write byte present |
| wrReady | output | 1 | Write byte taken this cycle when valid |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | Read byte present |
| rdReady | input | 1 | Requester takes the read byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| flowErr | output | 1 | Wait-state timeout, valid with done |
| csN | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data to device |
| miso | input | 1 | SPI data from device |

## Verification
The assertions check the serial-line rules on every cycle. SCLK idles low while chip select is high, chip select never rises during a byte, and MOSI holds still while SCLK is high. They also check the control rules: done lasts one cycle, flowErr only appears with done and a released chip select, write handshakes happen only while chip select is low, and the read stream is zero after a timeout. Only the bench scenarios, run against a device model, can show that the header contents are right and that the master's view of the ready bit matches the device's. They also show that the number of poll bytes, the byte count and order of each payload, behaviour under read backpressure, and the point where a timeout cuts the transaction off are all correct.

// File: rtl/tpm_xact_pkg.sv
`timescale 1ns/1ps
package tpm_xact_pkg;

  localparam int HDR_BYTES = 4;
  localparam int MAX_LEN   = 64;
  localparam int LEN_W     = $clog2(MAX_LEN);

  // Strobes from control to the serial datapath
  typedef struct packed {
    logic       csLow;
    logic       csHigh;
    logic       startByte;
    logic [7:0] txByte;
  } dpCmd_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETUP,
    S_HDR,
    S_POLL,
    S_GATE,
    S_PAY,
    S_RDHOLD,
    S_ZFILL,
    S_FINISH
  } xState_e;

endpackage

// File: rtl/tpm_xact_dp.sv
`timescale 1ns/1ps
module tpm_xact_dp
  import tpm_xact_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       miso,
  output logic       csN,
  output logic       sclk,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] divCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    txSh;
  logic [7:0]    rxSh;
  logic          running;
  logic          halfTick;

  assign halfTick = (divCnt == DW'(HALF_DIV - 1));
  assign mosi     = running ? txSh[7] : 1'b0;
  assign rxByte   = rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sclk     <= 1'b0;
      running  <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.csLow)  csN <= 1'b0;
      if (cmd.csHigh) csN <= 1'b1;
      if (cmd.startByte) begin
        txSh    <= cmd.txByte;
        bitCnt  <= '0;
        divCnt  <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitCnt == 3'd7) begin
              running  <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !csN);

  // R3
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/tpm_xact_ctrl.sv
`timescale 1ns/1ps
module tpm_xact_ctrl
  import tpm_xact_pkg::*;
#(
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLenM1,
  input  logic [23:0]      reqAddr,
  output logic             reqReady,
  output logic             busy,
  output logic             done,
  output logic             flowErr,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  input  logic             csN,
  output dpCmd_t           cmd
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  xState_e          state;
  logic             isRead;
  logic [LEN_W-1:0] lenM1;
  logic [LEN_W-1:0] payCnt;
  logic [23:0]      addr;
  logic [1:0]       hdrIdx;
  logic [TW-1:0]    timer;
  logic             errFlag;
  logic [7:0]       rdBuf;
  logic             expired;
  logic             lastByte;
  logic [7:0]       nextHdr;

  assign expired  = (timer >= TW'(TIMEOUT_CYC));
  assign lastByte = (payCnt == lenM1);
  assign reqReady = (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FINISH);
  assign flowErr  = done && errFlag;
  assign wrReady  = (state == S_GATE) && !isRead;
  assign rdValid  = (state == S_RDHOLD) || (state == S_ZFILL);
  assign rdData   = (state == S_ZFILL) ? 8'h00 : rdBuf;

  always_comb begin
    case (hdrIdx)
      2'd0:    nextHdr = addr[23:16];
      2'd1:    nextHdr = addr[15:8];
      default: nextHdr = addr[7:0];
    endcase
  end

  always_comb begin
    cmd = '0;
    case (state)
      S_IDLE:  cmd.csLow = reqValid;
      S_SETUP: begin
        cmd.startByte = 1'b1;
        cmd.txByte    = {isRead, 1'b1, lenM1};
      end
      S_HDR: if (byteDone) begin
        if (hdrIdx != 2'd3) begin
          cmd.startByte = 1'b1;
          cmd.txByte    = nextHdr;
        end else if (!rxByte[0]) begin
          cmd.startByte = 1'b1;
        end
      end
      S_POLL: if (byteDone && !rxByte[0]) begin
        if (expired) cmd.csHigh    = 1'b1;
        else         cmd.startByte = 1'b1;
      end
      S_GATE: begin
        cmd.startByte = isRead || wrValid;
        cmd.txByte    = isRead ? 8'h00 : wrData;
      end
      S_PAY:    cmd.csHigh = byteDone && !isRead && lastByte;
      S_RDHOLD: cmd.csHigh = rdReady && lastByte;
      default:  cmd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isRead  <= 1'b0;
      lenM1   <= '0;
      payCnt  <= '0;
      addr    <= '0;
      hdrIdx  <= '0;
      timer   <= '0;
      errFlag <= 1'b0;
      rdBuf   <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          isRead  <= reqRead;
          lenM1   <= reqLenM1;
          addr    <= reqAddr;
          payCnt  <= '0;
          errFlag <= 1'b0;
          state   <= S_SETUP;
        end
        S_SETUP: begin
          hdrIdx <= '0;
          state  <= S_HDR;
        end
        S_HDR: if (byteDone) begin
          if (hdrIdx != 2'd3) begin
            hdrIdx <= hdrIdx + 2'd1;
          end else if (rxByte[0]) begin
            state <= S_GATE;
          end else begin
            timer <= '0;
            state <= S_POLL;
          end
        end
        S_POLL: begin
          if (!expired) timer <= timer + TW'(1);
          if (byteDone) begin
            if (rxByte[0]) begin
              state <= S_GATE;
            end else if (expired) begin
              errFlag <= 1'b1;
              state   <= isRead ? S_ZFILL : S_FINISH;
            end
          end
        end
        S_GATE: if (isRead || wrValid) state <= S_PAY;
        S_PAY: if (byteDone) begin
          if (isRead) begin
            rdBuf <= rxByte;
            state <= S_RDHOLD;
          end else if (lastByte) begin
            state <= S_FINISH;
          end else begin
            payCnt <= payCnt + LEN_W'(1);
            state  <= S_GATE;
          end
        end
        S_RDHOLD: if (rdReady) begin
          if (lastByte) begin
            state <= S_FINISH;
          end else begin
            payCnt <= payCnt + LEN_W'(1);
            state  <= S_GATE;
          end
        end
        S_ZFILL: if (rdReady) begin
          if (lastByte) state <= S_FINISH;
          else          payCnt <= payCnt + LEN_W'(1);
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (busy && !csN));

  // R6
  err_with_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    flowErr |-> (done && csN));

  // R8
  wr_inside_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> !csN);

  // R7
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && errFlag) |-> (rdData == 8'h00 && csN));

endmodule

// File: rtl/tpm_spi_xact.sv
`timescale 1ns/1ps
module tpm_spi_xact
  import tpm_xact_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 20_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLenM1,
  input  logic [23:0]      reqAddr,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic             busy,
  output logic             done,
  output logic             flowErr,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  dpCmd_t     cmd;
  logic       byteDone;
  logic [7:0] rxByte;

  tpm_xact_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqRead(reqRead), .reqLenM1(reqLenM1),
    .reqAddr(reqAddr), .reqReady(reqReady),
    .busy(busy), .done(done), .flowErr(flowErr),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .byteDone(byteDone), .rxByte(rxByte), .csN(csN), .cmd(cmd)
  );

  tpm_xact_dp #(.HALF_DIV(HALF_DIV)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .miso(miso),
    .csN(csN), .sclk(sclk), .mosi(mosi),
    .byteDone(byteDone), .rxByte(rxByte)
  );

endmodule

// File: tb/tpm_spi_xact_tb_top.sv
`timescale 1ns/1ps
module tpm_spi_xact_tb_top;

  localparam int HALF = 2;
  localparam int TMO  = 400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        reqValid, reqReady, reqRead;
  logic [5:0]  reqLenM1;
  logic [23:0] reqAddr;
  logic [7:0]  wrData, rdData;
  logic        wrValid, wrReady, rdValid, rdReady;
  logic        busy, done, flowErr, csN, sclk, mosi;
  logic        misoR;

  tpm_spi_xact #(.HALF_DIV(HALF), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqRead(reqRead),
    .reqLenM1(reqLenM1), .reqAddr(reqAddr),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .busy(busy), .done(done), .flowErr(flowErr),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(misoR)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int          mWait;
  logic [23:0] mAddr;
  int          bitIdx;
  int          capCount;
  int          csFalls;
  logic [7:0]  inSh;
  logic [7:0]  cap [256];

  function automatic logic [7:0] rdPat(input int k);
    return 8'(mAddr[7:0] + k * 29 + 90);
  endfunction

  function automatic logic [7:0] respByte(input int n);
    int firstPay;
    firstPay = 4 + mWait;
    if (n < 3)         return 8'h00;
    if (n == 3)        return (mWait == 0) ? 8'h01 : 8'hFE;
    if (n < firstPay)  return (n == firstPay - 1) ? 8'h81 : 8'hFE;
    return rdPat(n - firstPay);
  endfunction

  function automatic logic misoBit(input int idx);
    logic [7:0] b;
    b = respByte(idx / 8);
    return b[7 - (idx % 8)];
  endfunction

  always @(negedge csN) begin
    bitIdx = 0;
    capCount = 0;
    csFalls++;
    misoR = misoBit(0);
  end

  always @(posedge sclk) if (!csN) begin
    inSh = {inSh[6:0], mosi};
    if (bitIdx % 8 == 7 && capCount < 256) begin
      cap[capCount] = inSh;
      capCount++;
    end
  end

  always @(negedge sclk) if (!csN) begin
    bitIdx++;
    misoR = misoBit(bitIdx);
  end

  // ---------------- transaction driver ----------------
  task automatic runXact(input bit rd, input int len, input logic [23:0] addr,
                         input int wt, input bit stall, input bit holdReq);
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];
    int  rn = 0, wi = 0, cyc = 0;
    bit  sawDone = 0, errSeen = 0, busyOk = 1, tmo;
    int  badCnt;
    logic [7:0] expH0;
    tmo = (wt > 50);
    mWait = wt; mAddr = addr; csFalls = 0;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(i * 13 + addr[3:0] + 7);
    @(negedge clk);
    chk(reqReady, "R10 ready before request", reqReady, 1);
    reqValid = 1'b1; reqRead = rd; reqLenM1 = 6'(len - 1); reqAddr = addr;
    @(negedge clk);
    if (holdReq) begin
      reqAddr = 24'hFFFFFF; reqRead = !rd; reqLenM1 = 6'd63;
    end else begin
      reqValid = 1'b0;
    end
    while (!sawDone && cyc < 20000) begin
      wrValid = (wi < len);
      wrData  = wbuf[wi % 64];
      rdReady = stall ? (cyc % 3 == 2) : 1'b1;
      if (!busy) busyOk = 0;
      if (wrReady && wrValid) wi++;
      if (rdValid && rdReady) begin
        if (rn < 64) rbuf[rn] = rdData;
        rn++;
      end
      if (done) begin
        sawDone = 1; errSeen = flowErr; reqValid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    wrValid = 1'b0; rdReady = 1'b0;
    chk(sawDone, "R10 done reached", sawDone, 1);
    chk(busyOk, "R10 busy held until done", busyOk, 1);
    chk(!busy && csN, "R10 idle after done", busy, 0);
    chk(csFalls == 1, "R3 single chip-select period", csFalls, 1);
    expH0 = {rd, 1'b1, 6'(len - 1)};
    chk(cap[0] == expH0, "R1 header byte 0", cap[0], expH0);
    chk({cap[1], cap[2], cap[3]} == addr, "R2 address bytes", {cap[1], cap[2], cap[3]}, addr);
    if (!tmo) begin
      chk(!errSeen, "R6 no error without timeout", errSeen, 0);
      chk(capCount == 4 + wt + len, wt == 0 ? "R4 byte count on wire" : "R5 byte count on wire",
          capCount, 4 + wt + len);
      badCnt = 0;
      for (int i = 0; i < wt; i++) if (cap[4 + i] != 8'h00) badCnt++;
      chk(badCnt == 0, "R5 poll bytes are 0x00", badCnt, 0);
      if (rd) begin
        chk(rn == len, "R9 read byte count", rn, len);
        badCnt = 0;
        for (int i = 0; i < len; i++) if (rbuf[i] != rdPat(i)) badCnt++;
        chk(badCnt == 0, len == 64 ? "R11 read data 64 bytes" : "R9 read data order", badCnt, 0);
        badCnt = 0;
        for (int i = 0; i < len; i++) if (cap[4 + wt + i] != 8'h00) badCnt++;
        chk(badCnt == 0, "R9 read payload sends 0x00", badCnt, 0);
      end else begin
        chk(wi == len, "R8 write handshakes", wi, len);
        badCnt = 0;
        for (int i = 0; i < len; i++) if (cap[4 + wt + i] != wbuf[i]) badCnt++;
        chk(badCnt == 0, len == 64 ? "R11 write data 64 bytes" : "R8 write data order", badCnt, 0);
      end
    end else begin
      chk(errSeen, "R6 flow error flagged", errSeen, 1);
      chk(capCount > 4 && capCount < 30, "R6 stopped during polling", capCount, 16);
      badCnt = 0;
      for (int i = 4; i < capCount && i < 256; i++) if (cap[i] != 8'h00) badCnt++;
      chk(badCnt == 0, "R6 only poll bytes after header", badCnt, 0);
      if (rd) begin
        chk(rn == len, "R7 zero-fill byte count", rn, len);
        badCnt = 0;
        for (int i = 0; i < len && i < 64; i++) if (rbuf[i] != 8'h00) badCnt++;
        chk(badCnt == 0, "R7 zero-fill data", badCnt, 0);
      end else begin
        chk(wi == 0, "R6 no write data taken", wi, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int lens [4];
    int waits [3];
    logic [23:0] addrs [3];
    int n = 0;
    lens  = '{1, 2, 5, 64};
    waits = '{0, 1, 4};
    addrs = '{24'hD40018, 24'hD40024, 24'hD40F00};
    rstN = 1'b0; reqValid = 1'b0; reqRead = 1'b0; reqLenM1 = '0; reqAddr = '0;
    wrData = '0; wrValid = 1'b0; rdReady = 1'b0; mWait = 0; mAddr = '0;
    misoR = 1'b0; csFalls = 0; capCount = 0; bitIdx = 0; inSh = '0;
    repeat (5) @(negedge clk);
    chk(csN && !sclk, "R3 reset line state", {csN, sclk}, 2);
    chk(!busy && reqReady, "R10 reset idle", busy, 0);
    chk(!done && !rdValid && !wrReady, "R10 reset outputs quiet", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 2; r++)
      for (int l = 0; l < 4; l++)
        for (int w = 0; w < 3; w++) begin
          runXact(r[0], lens[l], addrs[n % 3], waits[w], lens[l] == 5, 1'b0);
          n++;
        end
    runXact(1'b1, 3, 24'hD40024, 2, 1'b1, 1'b1);   // R10 request held during transaction
    runXact(1'b0, 4, 24'hD40018, 0, 1'b0, 1'b1);   // R10
    runXact(1'b1, 4, 24'hD40F00, 100000, 1'b1, 1'b0); // R6 R7
    runXact(1'b0, 3, 24'hD40024, 100000, 1'b0, 1'b0); // R6
    runXact(1'b1, 64, 24'hD40024, 100000, 1'b0, 1'b0); // R7 R11
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule